// File: doc/BRIEF.md
# Motor-commutation event interrupt collector

This block watches the event sources around a motor-commutation pulse generator and turns them into three grouped interrupt request lines. It observes five kinds of event:

- a 3-bit rotor position input, either by level match against the 3-bit output-data field or by a selectable edge type on any bit;
- equality of the output-data field and the compare-data field;
- a low level on the active-low emergency shutdown pin;
- a write-timing strobe;
- equality of a 16-bit timer count and a 16-bit compare-clear value.

Each event is gated by its own enable bit. An enabled event sets a sticky flag. Software removes a flag with a write-1-to-clear pulse.

Line A reports the shutdown flag. Line B groups the write-timing and compare-clear flags. Line C groups the position and compare-match flags.

The position input first passes through a two-flop synchronizer, followed by a history register. A small state machine in the position detector blocks position events until that pipeline holds real samples. It has four states:

- `ST_FILL_A`, `ST_FILL_B` and `ST_FILL_C` are the three fill states, one per clock edge after reset.
- `ST_WATCH` is the operating state.

Its transitions are `FILL_A->FILL_B`, `FILL_B->FILL_C`, `FILL_C->WATCH` and `WATCH->WATCH`, and each is taken unconditionally on every edge. Reset returns the machine to `ST_FILL_A`.

Top module: `mpg_irq_hub`

## Requirements
- R1: While reset is asserted and after its release, all five flags and all three interrupt lines are 0.
- R2: With `edge_sel` 00 (rising), 01 (falling) or 10 (either), a matching transition on any synchronized position bit with `en_pos` = 1 sets `flag_pos`. The flag rises on the third rising clock edge after the input changes.
- R3: With `edge_sel` 11 (level mode), `flag_pos` is set whenever the synchronized position equals `out_data` and `en_pos` = 1. The same three-edge latency applies.
- R4: `out_data` equal to `cmp_data` with `en_cmp` = 1 sets `flag_cmp` on the next rising edge.
- R5: `shdn_n` low with `en_shdn` = 1 sets `flag_shdn` on the next rising edge.
- R6: `wr_strobe` high with `en_wr` = 1 sets `flag_wr` on the next rising edge.
- R7: `tmr_cnt` equal to `clr_val` with `en_clr` = 1 sets `flag_clr` on the next rising edge.
- R8: An event whose enable bit is 0 has no effect on its flag.
- R9: A flag stays at 1 until its `w1c_*` input is 1 at a rising edge, and it then clears. When a set and a clear meet at the same edge, the flag stays at 1.
- R10: `irq_a` equals `flag_shdn`. `irq_b` is `flag_wr` OR `flag_clr`. `irq_c` is `flag_pos` OR `flag_cmp`.
- R11: Position events are ignored during the first three clock cycles after reset release, while the detector is in its fill states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_in | input | 3 | Rotor position inputs |
| out_data | input | 3 | Output-data field |
| cmp_data | input | 3 | Compare-data field |
| edge_sel | input | 2 | Position mode: 00 rising, 01 falling, 10 either, 11 level |
| shdn_n | input | 1 | Emergency shutdown, active low |
| wr_strobe | input | 1 | Write-timing strobe |
| tmr_cnt | input | 16 | Timer count |
| clr_val | input | 16 | Compare-clear value |
| en_pos | input | 1 | Position event enable |
| en_cmp | input | 1 | Compare-match enable |
| en_shdn | input | 1 | Shutdown enable |
| en_wr | input | 1 | Write-timing enable |
| en_clr | input | 1 | Compare-clear enable |
| w1c_pos | input | 1 | Clear pulse for flag_pos |
| w1c_cmp | input | 1 | Clear pulse for flag_cmp |
| w1c_shdn | input | 1 | Clear pulse for flag_shdn |
| w1c_wr | input | 1 | Clear pulse for flag_wr |
| w1c_clr | input | 1 | Clear pulse for flag_clr |
| flag_pos | output | 1 | Position flag |
| flag_cmp | output | 1 | Compare-match flag |
| flag_shdn | output | 1 | Shutdown flag |
| flag_wr | output | 1 | Write-timing flag |
| flag_clr | output | 1 | Compare-clear flag |
| irq_a | output | 1 | Shutdown request line |
| irq_b | output | 1 | Write-timing / compare-clear request line |
| irq_c | output | 1 | Position / compare-match request line |

## Verification
The compare-match, shutdown, write-timing and compare-clear results are due one rising edge after the stimulus. Position results are due three edges after a change on `pos_in`. The interrupt lines follow the flags in the same cycle.

The bench drives every input at a falling edge and checks all eight outputs at the following falling edge. Its reference model advances exactly one clock per check. That model keeps its own three-deep position history and an edge count since reset, so each position result is checked exactly in its due cycle and never earlier or later.

// File: rtl/mpg_irq_pkg.sv
package mpg_irq_pkg;

    localparam int NUM_FLAGS = 5;
    localparam int F_POS  = 0;
    localparam int F_CMP  = 1;
    localparam int F_SHDN = 2;
    localparam int F_WR   = 3;
    localparam int F_CLR  = 4;

    localparam logic [1:0] EDGE_RISE = 2'b00;
    localparam logic [1:0] EDGE_FALL = 2'b01;
    localparam logic [1:0] EDGE_BOTH = 2'b10;
    localparam logic [1:0] MODE_LVL  = 2'b11;

    typedef enum logic [1:0] {
        ST_FILL_A = 2'd0,
        ST_FILL_B = 2'd1,
        ST_FILL_C = 2'd2,
        ST_WATCH  = 2'd3
    } pos_state_t;

endpackage

// File: rtl/mpg_pos_detect.sv
module mpg_pos_detect
    import mpg_irq_pkg::*;
#(
    parameter int POS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_in,
    input  logic [POS_W-1:0] out_data,
    input  logic [1:0]       edge_sel,
    output logic             pos_evt
);

    logic [POS_W-1:0] sync_a;
    logic [POS_W-1:0] sync_b;
    logic [POS_W-1:0] hist;
    pos_state_t       st_q;
    pos_state_t       st_d;
    logic             any_rise;
    logic             any_fall;
    logic             any_chg;
    logic             lvl_hit;
    logic             cond_hit;

    // synchronizer and history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
            hist   <= '0;
        end else begin
            sync_a <= pos_in;
            sync_b <= sync_a;
            hist   <= sync_b;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_FILL_A;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FILL_A: st_d = ST_FILL_B;
            ST_FILL_B: st_d = ST_FILL_C;
            ST_FILL_C: st_d = ST_WATCH;
            ST_WATCH:  st_d = ST_WATCH;
            default:   st_d = ST_FILL_A;
        endcase
    end

    assign any_rise = |(sync_b & ~hist);
    assign any_fall = |(~sync_b & hist);
    assign any_chg  = |(sync_b ^ hist);
    assign lvl_hit  = (sync_b == out_data);

    always_comb begin
        cond_hit = 1'b0;
        unique case (edge_sel)
            EDGE_RISE: cond_hit = any_rise;
            EDGE_FALL: cond_hit = any_fall;
            EDGE_BOTH: cond_hit = any_chg;
            MODE_LVL:  cond_hit = lvl_hit;
            default:   cond_hit = 1'b0;
        endcase
    end

    // outputs per state
    always_comb begin
        pos_evt = 1'b0;
        unique case (st_q)
            ST_FILL_A, ST_FILL_B, ST_FILL_C: pos_evt = 1'b0;
            ST_WATCH:                        pos_evt = cond_hit;
            default:                         pos_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/mpg_event_cmp.sv
module mpg_event_cmp #(
    parameter int POS_W = 3,
    parameter int TMR_W = 16
) (
    input  logic [POS_W-1:0] out_data,
    input  logic [POS_W-1:0] cmp_data,
    input  logic [TMR_W-1:0] tmr_cnt,
    input  logic [TMR_W-1:0] clr_val,
    output logic             cmp_evt,
    output logic             clr_evt
);

    assign cmp_evt = (out_data == cmp_data);
    assign clr_evt = (tmr_cnt == clr_val);

endmodule

// File: rtl/mpg_flag_bank.sv
module mpg_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flag_vec
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_vec[i] <= 1'b0;
            else if (set_vec[i]) flag_vec[i] <= 1'b1;
            else if (clr_vec[i]) flag_vec[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/mpg_irq_hub.sv
module mpg_irq_hub
    import mpg_irq_pkg::*;
#(
    parameter int POS_W = 3,
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_in,
    input  logic [POS_W-1:0] out_data,
    input  logic [POS_W-1:0] cmp_data,
    input  logic [1:0]       edge_sel,
    input  logic             shdn_n,
    input  logic             wr_strobe,
    input  logic [TMR_W-1:0] tmr_cnt,
    input  logic [TMR_W-1:0] clr_val,
    input  logic             en_pos,
    input  logic             en_cmp,
    input  logic             en_shdn,
    input  logic             en_wr,
    input  logic             en_clr,
    input  logic             w1c_pos,
    input  logic             w1c_cmp,
    input  logic             w1c_shdn,
    input  logic             w1c_wr,
    input  logic             w1c_clr,
    output logic             flag_pos,
    output logic             flag_cmp,
    output logic             flag_shdn,
    output logic             flag_wr,
    output logic             flag_clr,
    output logic             irq_a,
    output logic             irq_b,
    output logic             irq_c
);

    logic                 pos_evt;
    logic                 cmp_evt;
    logic                 clr_evt;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flag_vec;

    mpg_pos_detect #(.POS_W(POS_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos_in   (pos_in),
        .out_data (out_data),
        .edge_sel (edge_sel),
        .pos_evt  (pos_evt)
    );

    mpg_event_cmp #(.POS_W(POS_W), .TMR_W(TMR_W)) u_cmp (
        .out_data (out_data),
        .cmp_data (cmp_data),
        .tmr_cnt  (tmr_cnt),
        .clr_val  (clr_val),
        .cmp_evt  (cmp_evt),
        .clr_evt  (clr_evt)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[F_POS]  = pos_evt & en_pos;
        set_vec[F_CMP]  = cmp_evt & en_cmp;
        set_vec[F_SHDN] = ~shdn_n & en_shdn;
        set_vec[F_WR]   = wr_strobe & en_wr;
        set_vec[F_CLR]  = clr_evt & en_clr;
        clr_vec         = '0;
        clr_vec[F_POS]  = w1c_pos;
        clr_vec[F_CMP]  = w1c_cmp;
        clr_vec[F_SHDN] = w1c_shdn;
        clr_vec[F_WR]   = w1c_wr;
        clr_vec[F_CLR]  = w1c_clr;
    end

    mpg_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .flag_vec (flag_vec)
    );

    assign flag_pos  = flag_vec[F_POS];
    assign flag_cmp  = flag_vec[F_CMP];
    assign flag_shdn = flag_vec[F_SHDN];
    assign flag_wr   = flag_vec[F_WR];
    assign flag_clr  = flag_vec[F_CLR];

    assign irq_a = flag_vec[F_SHDN];
    assign irq_b = flag_vec[F_WR] | flag_vec[F_CLR];
    assign irq_c = flag_vec[F_POS] | flag_vec[F_CMP];

endmodule

// File: rtl/mpg_irq_hub_chk.sv
module mpg_irq_hub_chk #(
    parameter int POS_W = 3,
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [POS_W-1:0] out_data,
    input logic [POS_W-1:0] cmp_data,
    input logic             shdn_n,
    input logic             wr_strobe,
    input logic [TMR_W-1:0] tmr_cnt,
    input logic [TMR_W-1:0] clr_val,
    input logic             en_cmp,
    input logic             en_shdn,
    input logic             en_wr,
    input logic             en_clr,
    input logic             w1c_cmp,
    input logic             w1c_shdn,
    input logic             flag_cmp,
    input logic             flag_shdn,
    input logic             irq_a,
    input logic             irq_b,
    input logic             irq_c
);

    p_cmp_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cmp && out_data == cmp_data) |=> flag_cmp);

    p_shdn_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_shdn && !shdn_n) |=> irq_a);

    p_wr_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && wr_strobe) |=> irq_b);

    p_clr_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr && tmr_cnt == clr_val) |=> irq_b);

    p_no_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_shdn) |-> $past(en_shdn && !shdn_n));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_cmp && !w1c_cmp) |=> flag_cmp);

    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_shdn && !(en_shdn && !shdn_n)) |=> !flag_shdn);

    p_line_c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_cmp |-> irq_c);

endmodule

bind mpg_irq_hub mpg_irq_hub_chk #(.POS_W(POS_W), .TMR_W(TMR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_data  (out_data),
    .cmp_data  (cmp_data),
    .shdn_n    (shdn_n),
    .wr_strobe (wr_strobe),
    .tmr_cnt   (tmr_cnt),
    .clr_val   (clr_val),
    .en_cmp    (en_cmp),
    .en_shdn   (en_shdn),
    .en_wr     (en_wr),
    .en_clr    (en_clr),
    .w1c_cmp   (w1c_cmp),
    .w1c_shdn  (w1c_shdn),
    .flag_cmp  (flag_cmp),
    .flag_shdn (flag_shdn),
    .irq_a     (irq_a),
    .irq_b     (irq_b),
    .irq_c     (irq_c)
);

// File: tb/mpg_irq_hub_tb_top.sv
module mpg_irq_hub_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pos_in = '0;
    logic [2:0]  out_data = '0;
    logic [2:0]  cmp_data = 3'd1;
    logic [1:0]  edge_sel = '0;
    logic        shdn_n = 1'b1;
    logic        wr_strobe = 1'b0;
    logic [15:0] tmr_cnt = '0;
    logic [15:0] clr_val = 16'hFFFF;
    logic        en_pos = 0, en_cmp = 0, en_shdn = 0, en_wr = 0, en_clr = 0;
    logic        w1c_pos = 0, w1c_cmp = 0, w1c_shdn = 0, w1c_wr = 0, w1c_clr = 0;
    logic        flag_pos, flag_cmp, flag_shdn, flag_wr, flag_clr;
    logic        irq_a, irq_b, irq_c;

    int total = 0;
    int bad = 0;

    // reference model state
    logic [2:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;
    int         m_edges = 0;
    logic [4:0] m_flag = '0;  // 0 pos,1 cmp,2 shdn,3 wr,4 clr

    always #10 clk = ~clk;

    mpg_irq_hub dut_i (
        .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .out_data(out_data),
        .cmp_data(cmp_data), .edge_sel(edge_sel), .shdn_n(shdn_n),
        .wr_strobe(wr_strobe), .tmr_cnt(tmr_cnt), .clr_val(clr_val),
        .en_pos(en_pos), .en_cmp(en_cmp), .en_shdn(en_shdn), .en_wr(en_wr),
        .en_clr(en_clr), .w1c_pos(w1c_pos), .w1c_cmp(w1c_cmp),
        .w1c_shdn(w1c_shdn), .w1c_wr(w1c_wr), .w1c_clr(w1c_clr),
        .flag_pos(flag_pos), .flag_cmp(flag_cmp), .flag_shdn(flag_shdn),
        .flag_wr(flag_wr), .flag_clr(flag_clr),
        .irq_a(irq_a), .irq_b(irq_b), .irq_c(irq_c)
    );

    task automatic chk(input string tag, input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, req, act, exp, $time);
        end
    endtask

    function automatic logic pos_hit(input logic [1:0] sel, input logic [2:0] cur,
                                     input logic [2:0] old, input logic [2:0] od);
        case (sel)
            2'b00:   return |(cur & ~old);
            2'b01:   return |(~cur & old);
            2'b10:   return cur != old;
            default: return cur == od;
        endcase
    endfunction

    // compare outputs with model, then advance model over the next edge
    task automatic check_all(input string tag);
        chk(tag, (edge_sel == 2'b11) ? "R3 flag_pos" : "R2 flag_pos", flag_pos, m_flag[0]);
        chk(tag, "R4 flag_cmp",  flag_cmp,  m_flag[1]);
        chk(tag, "R5 flag_shdn", flag_shdn, m_flag[2]);
        chk(tag, "R6 flag_wr",   flag_wr,   m_flag[3]);
        chk(tag, "R7 flag_clr",  flag_clr,  m_flag[4]);
        chk(tag, "R10 irq_a", irq_a, m_flag[2]);
        chk(tag, "R10 irq_b", irq_b, m_flag[3] | m_flag[4]);
        chk(tag, "R10 irq_c", irq_c, m_flag[0] | m_flag[1]);
    endtask

    task automatic advance(input string tag);
        logic [4:0] s, c;
        check_all(tag);
        s[0] = en_pos && (m_edges >= 3) && pos_hit(edge_sel, m_s2, m_s3, out_data);
        s[1] = en_cmp && (out_data == cmp_data);
        s[2] = en_shdn && !shdn_n;
        s[3] = en_wr && wr_strobe;
        s[4] = en_clr && (tmr_cnt == clr_val);
        c = {w1c_clr, w1c_wr, w1c_shdn, w1c_cmp, w1c_pos};
        m_flag = s | (m_flag & ~c);
        m_s3 = m_s2;
        m_s2 = m_s1;
        m_s1 = pos_in;
        m_edges++;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        shdn_n = 1; wr_strobe = 0; cmp_data = out_data + 3'd1; clr_val = tmr_cnt + 16'd1;
        {w1c_pos, w1c_cmp, w1c_shdn, w1c_wr, w1c_clr} = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        // R1: state during reset
        @(posedge clk); @(negedge clk);
        check_all("R1");
        rst_n = 1;
        // R11: level match present right from reset, ignored in fill states
        edge_sel = 2'b11; pos_in = 3'd5; out_data = 3'd5; cmp_data = 3'd2;
        en_pos = 1;
        for (int i = 0; i < 6; i++) advance("R11");
        // R9: clear pulse then clear of position flag
        w1c_pos = 1; out_data = 3'd6; advance("R9");
        for (int i = 0; i < 3; i++) advance("R9");
        w1c_pos = 0;
        // R8: all events active with enables off
        en_pos = 0; quiet(); shdn_n = 0; wr_strobe = 1; cmp_data = out_data;
        clr_val = tmr_cnt; w1c_cmp = 1;
        for (int i = 0; i < 3; i++) advance("R8");
        // R9: set wins over clear
        en_cmp = 1; en_shdn = 1; w1c_shdn = 1;
        for (int i = 0; i < 2; i++) advance("R9");
        quiet(); w1c_shdn = 1; w1c_cmp = 1; advance("R9"); advance("R9");
        quiet(); en_wr = 1; en_clr = 1;
        // R2: each edge kind
        en_pos = 1;
        for (int k = 0; k < 3; k++) begin
            edge_sel = 2'(k);
            w1c_pos = 1; advance("R2"); w1c_pos = 0;
            pos_in = 3'b000; for (int i = 0; i < 4; i++) advance("R2");
            pos_in = 3'b010; for (int i = 0; i < 4; i++) advance("R2");
            w1c_pos = 1; advance("R2"); w1c_pos = 0;
            pos_in = 3'b000; for (int i = 0; i < 4; i++) advance("R2");
        end
        // random phase
        for (int n = 0; n < 4000; n++) begin
            pos_in    = 3'($urandom);
            out_data  = 3'($urandom);
            cmp_data  = ($urandom % 4 == 0) ? out_data : 3'($urandom);
            edge_sel  = 2'($urandom);
            shdn_n    = ($urandom % 8 != 0);
            wr_strobe = ($urandom % 6 == 0);
            tmr_cnt   = 16'($urandom);
            clr_val   = ($urandom % 5 == 0) ? tmr_cnt : 16'($urandom);
            {en_pos, en_cmp, en_shdn, en_wr, en_clr} = 5'($urandom) | 5'($urandom);
            {w1c_pos, w1c_cmp, w1c_shdn, w1c_wr, w1c_clr} = 5'($urandom) & 5'($urandom);
            advance("RND");
        end
        check_all("END");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule